// File: doc/BRIEF.md
# Nine-bit three-wire panel writer

This block sends single 9-bit words to a display panel over a write-only three-wire serial link: an active-low chip select, a serial clock and a data output. The leading bit of each word tells the panel whether the remaining eight bits are a command or a parameter byte. A requester hands over a type flag and a value with a valid/ready handshake. The block captures them, builds the word and clocks it out most significant bit first. It then returns the line to its all-high idle state and only after that accepts the next word.

Each bit is sent as a clock-low half period followed by a clock-high half period, and the panel samples data on the rising clock edge. The half period is given in system clock cycles. A build parameter selects whether it comes from an input port, captured with each word, or from a fixed parameter. The nominal setting is 10 µs per half, which is 1000 cycles at 100 MHz.

Top module: `w9_serial_tx`

## Requirements
- R1: Out of reset, and whenever no word is in flight, chip select, clock and data are all high and ready is high.
- R2: The word sent is 9 bits. Bit 8 is 1 when the type flag input is nonzero and 0 when it is zero. Bits 7:0 are the low 8 bits of the value input.
- R3: Exactly 9 rising clock edges occur while chip select is low, and the word is sent bit 8 first, down to bit 0.
- R4: For each bit, the data line changes only when the clock falls. The clock then stays low for exactly H cycles and high for exactly H cycles, and data is stable while the clock is high.
- R5: H is the half-period count, captured at acceptance. With the port variant it is taken from the half-period input, and a value of 0 is treated as 1. With the fixed variant it is the parameter value. Changes to the input during a frame have no effect on that frame.
- R6: Chip select falls in the cycle after acceptance, together with the first clock fall. It rises one cycle after the end of the ninth clock-high half.
- R7: Ready is low from the acceptance edge for exactly 19·H cycles. Between two frames, chip select stays high for at least H+1 cycles.
- R8: Valid, type and value inputs presented while ready is low are ignored: the word in flight is unchanged and no extra frame is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A word is offered |
| in_ready | output | 1 | Block is idle and takes the offered word |
| in_kind | input | TYPE_W | Type flag; any nonzero value sets bit 8 |
| in_value | input | VAL_W | Value; the low 8 bits are sent |
| half_cycles | input | CNT_W | Half period in cycles (port variant) |
| pin_cs_n | output | 1 | Serial chip select, active low |
| pin_sclk | output | 1 | Serial clock |
| pin_sdo | output | 1 | Serial data out |

## Verification
The hardest situation to reach is a second word that arrives exactly as the line goes idle, while the inputs are also being changed mid-frame. The stimulus holds valid high back-to-back so that the inter-frame gap is at its minimum. During frames it also drives valid with junk data and changes the half-period input, then shows through the pins that neither the word in flight nor its timing moved. Half-period values of 0 and 1 are included to hit the one-cycle phase case.

// File: rtl/w9_pkg.sv
package w9_pkg;
   localparam int FRAME_BITS = 9;
   localparam int BYTE_BITS  = 8;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2,
      PH_GAP  = 2'd3
   } w9_phase_t;

   function automatic logic [FRAME_BITS-1:0] w9_pack(input logic flag,
                                                     input logic [BYTE_BITS-1:0] b);
      return {flag, b};
   endfunction
endpackage

// File: rtl/w9_div_select.sv
module w9_div_select #(
   parameter int CNT_W         = 16,
   parameter bit FROM_PORT     = 1'b1,
   parameter int HALF_DEFAULT  = 1000
) (
   input  logic [CNT_W-1:0] half_in,
   output logic [CNT_W-1:0] half_eff
);
   logic [CNT_W-1:0] src;

   generate
      if (FROM_PORT) begin : g_port
         assign src = half_in;
      end else begin : g_fixed
         localparam logic [CNT_W-1:0] FIXED = CNT_W'(HALF_DEFAULT);
         logic unused_in;
         assign unused_in = ^half_in;
         assign src = FIXED;
      end
   endgenerate

   // a zero count would stall the phase timer; clamp to one cycle
   assign half_eff = (src == '0) ? CNT_W'(1) : src;
endmodule

// File: rtl/w9_half_timer.sv
module w9_half_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] len,
   output logic             expire
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (start)        cnt <= len;
      else if (cnt != '0)    cnt <= cnt - CNT_W'(1);
   end

   assign expire = (cnt == CNT_W'(1));
endmodule

// File: rtl/w9_frame_seq.sv
module w9_frame_seq
   import w9_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  accept,
   input  logic [FRAME_BITS-1:0] word_in,
   input  logic [CNT_W-1:0]      half_in,
   output w9_phase_t             phase,
   output logic                  data_bit
);
   localparam int BC_W = $clog2(FRAME_BITS + 1);

   logic [FRAME_BITS-1:0] shreg;
   logic [BC_W-1:0]       bits_left;
   logic [CNT_W-1:0]      half_q;
   logic                  t_start;
   logic                  t_expire;
   logic                  last_bit;

   assign last_bit = (bits_left == BC_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         shreg     <= '1;
         bits_left <= '0;
         half_q    <= CNT_W'(1);
      end else begin
         unique case (phase)
            PH_IDLE: if (accept) begin
               phase     <= PH_LOW;
               shreg     <= word_in;
               bits_left <= BC_W'(FRAME_BITS);
               half_q    <= half_in;
            end
            PH_LOW: if (t_expire) phase <= PH_HIGH;
            PH_HIGH: if (t_expire) begin
               shreg     <= {shreg[FRAME_BITS-2:0], 1'b1};
               bits_left <= bits_left - BC_W'(1);
               phase     <= last_bit ? PH_GAP : PH_LOW;
            end
            PH_GAP: if (t_expire) phase <= PH_IDLE;
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // every phase change except the one into idle reloads the timer
   always_comb begin
      t_start = 1'b0;
      if (phase == PH_IDLE) t_start = accept;
      else if (phase != PH_GAP) t_start = t_expire;
   end

   w9_half_timer #(.CNT_W(CNT_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (t_start),
      .len    ((phase == PH_IDLE) ? half_in : half_q),
      .expire (t_expire)
   );

   assign data_bit = shreg[FRAME_BITS-1];
endmodule

// File: rtl/w9_serial_tx.sv
module w9_serial_tx
   import w9_pkg::*;
#(
   parameter int VAL_W         = 8,
   parameter int TYPE_W        = 8,
   parameter int CNT_W         = 16,
   parameter bit DIV_FROM_PORT = 1'b1,
   parameter int HALF_DEFAULT  = 1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [TYPE_W-1:0] in_kind,
   input  logic [VAL_W-1:0]  in_value,
   input  logic [CNT_W-1:0]  half_cycles,
   output logic              pin_cs_n,
   output logic              pin_sclk,
   output logic              pin_sdo
);
   generate
      if (VAL_W < BYTE_BITS) begin : g_bad_val
         $error("VAL_W must be at least 8");
      end
      if (TYPE_W < 1 || CNT_W < 1) begin : g_bad_w
         $error("TYPE_W and CNT_W must be positive");
      end
      if (HALF_DEFAULT < 1 || HALF_DEFAULT >= (64'd1 << CNT_W)) begin : g_bad_half
         $error("HALF_DEFAULT must be nonzero and fit in CNT_W bits");
      end
   endgenerate

   w9_phase_t             phase;
   logic                  data_bit;
   logic                  accept;
   logic [CNT_W-1:0]      half_eff;
   logic [FRAME_BITS-1:0] word;
   logic                  in_frame;

   generate
      if (VAL_W > BYTE_BITS) begin : g_wide
         logic unused_hi;
         assign unused_hi = ^in_value[VAL_W-1:BYTE_BITS];
      end
   endgenerate

   assign word     = w9_pack(|in_kind, in_value[BYTE_BITS-1:0]);
   assign in_ready = (phase == PH_IDLE);
   assign accept   = in_valid && in_ready;

   w9_div_select #(
      .CNT_W        (CNT_W),
      .FROM_PORT    (DIV_FROM_PORT),
      .HALF_DEFAULT (HALF_DEFAULT)
   ) u_div (
      .half_in  (half_cycles),
      .half_eff (half_eff)
   );

   w9_frame_seq #(.CNT_W(CNT_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .word_in  (word),
      .half_in  (half_eff),
      .phase    (phase),
      .data_bit (data_bit)
   );

   assign in_frame = (phase == PH_LOW) || (phase == PH_HIGH);
   assign pin_cs_n = !in_frame;
   assign pin_sclk = (phase != PH_LOW);
   assign pin_sdo  = in_frame ? data_bit : 1'b1;
endmodule

// File: rtl/w9_serial_tx_chk.sv
module w9_serial_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic in_valid,
   input logic in_ready,
   input logic pin_cs_n,
   input logic pin_sclk,
   input logic pin_sdo
);
   logic       prev_sclk;
   logic [3:0] rises;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_sclk <= 1'b1;
         rises     <= '0;
      end else begin
         prev_sclk <= pin_sclk;
         if (pin_cs_n) rises <= '0;
         else if (pin_sclk && !prev_sclk) rises <= rises + 4'd1;
      end
   end

   a_r1_idle_pins_high: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> (pin_cs_n && pin_sclk && pin_sdo));

   a_r3_nine_rises: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pin_cs_n) |-> (rises == 4'd9));

   a_r4_data_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (!pin_cs_n && $past(!pin_cs_n) && !$stable(pin_sdo)) |-> $fell(pin_sclk));

   a_r6_cs_rises_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pin_cs_n) |-> (pin_sclk && $past(pin_sclk)));

   a_r7_busy_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_cs_n |-> !in_ready);

   a_r7_ready_drops_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (!in_ready && $fell(pin_cs_n)));
endmodule

bind w9_serial_tx w9_serial_tx_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .pin_cs_n (pin_cs_n),
   .pin_sclk (pin_sclk),
   .pin_sdo  (pin_sdo)
);

// File: tb/w9_serial_tx_tb.sv
module w9_serial_tx_tb;
   localparam int CNT_W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [7:0]        in_kind = '0;
   logic [15:0]       in_value = '0;
   logic [CNT_W-1:0]  half_cycles = '0;
   logic              pin_cs_n, pin_sclk, pin_sdo;

   logic              f_valid = 1'b0;
   logic              f_ready, f_cs_n, f_sclk, f_sdo;

   w9_serial_tx #(.VAL_W(16), .TYPE_W(8), .CNT_W(CNT_W), .DIV_FROM_PORT(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_kind(in_kind), .in_value(in_value), .half_cycles(half_cycles),
      .pin_cs_n(pin_cs_n), .pin_sclk(pin_sclk), .pin_sdo(pin_sdo));

   w9_serial_tx #(.VAL_W(8), .TYPE_W(1), .CNT_W(CNT_W), .DIV_FROM_PORT(1'b0),
                  .HALF_DEFAULT(2)) u_fix (
      .clk(clk), .rst_n(rst_n), .in_valid(f_valid), .in_ready(f_ready),
      .in_kind(1'b1), .in_value(8'h5A), .half_cycles(CNT_W'(7)),
      .pin_cs_n(f_cs_n), .pin_sclk(f_sclk), .pin_sdo(f_sdo));

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [8:0] exp_word(input logic [7:0] k, input logic [15:0] v);
      return {(k != 8'd0), v[7:0]};
   endfunction

   function automatic int eff_half(input int h);
      return (h == 0) ? 1 : h;
   endfunction

   // expectations shared with the pin monitor
   logic [8:0] m_exp_word;
   int         m_exp_h = 1;
   int         m_prev_h = 0;

   // pin monitor, sampled on the falling edge
   logic p_cs = 1'b1, p_sclk = 1'b1, p_sdo = 1'b1;
   int   lowlen = 0, highlen = 0, nbits = 0, gaplen = 0;
   logic [8:0] cap = '0;
   bit   seen_frame = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (p_cs && !pin_cs_n) begin
            if (seen_frame)
               chk(gaplen >= m_prev_h + 1, "R7 gap", gaplen, m_prev_h + 1);
            chk(!pin_sclk, "R6 cs falls with clock low", pin_sclk, 0);
            nbits = 0; cap = '0; lowlen = 0; highlen = 0;
         end
         if (!pin_cs_n) begin
            if (!pin_sclk) begin
               if (p_sclk && !p_cs)
                  chk(highlen == m_exp_h, "R4 high half", highlen, m_exp_h);
               if (p_sclk) lowlen = 0;
               lowlen++;
            end else begin
               if (!p_sclk) begin
                  chk(lowlen == m_exp_h, "R4 low half", lowlen, m_exp_h);
                  cap = {cap[7:0], pin_sdo};
                  nbits++;
                  highlen = 0;
               end else if (pin_sdo != p_sdo) begin
                  chk(1'b0, "R4 data moved while clock high", pin_sdo, p_sdo);
               end
               highlen++;
            end
         end
         if (!p_cs && pin_cs_n) begin
            chk(highlen == m_exp_h, "R6 last high half before cs rise", highlen, m_exp_h);
            chk(nbits == 9, "R3 bit count", nbits, 9);
            chk(cap == m_exp_word, "R2 R3 word", cap, m_exp_word);
            m_prev_h = m_exp_h;
            seen_frame = 1'b1;
            gaplen = 0;
         end
         if (pin_cs_n) gaplen++;
      end
      p_cs = pin_cs_n; p_sclk = pin_sclk; p_sdo = pin_sdo;
   end

   // offer a word; returns after the frame, counting ready-low cycles
   task automatic send(input logic [7:0] k, input logic [15:0] v, input int h,
                       input bit keep_valid, input bit disturb);
      int lowcnt;
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_kind = k; in_value = v; half_cycles = CNT_W'(h);
      m_exp_word = exp_word(k, v);
      m_exp_h = eff_half(h);
      @(posedge clk);
      @(negedge clk);
      if (!keep_valid) in_valid = 1'b0;
      lowcnt = 0;
      if (disturb) begin
         // R8 / R5: junk offers and a new half count during the frame
         in_valid = 1'b1; in_kind = ~k; in_value = ~v; half_cycles = CNT_W'(h + 3);
      end
      while (!in_ready) begin
         lowcnt++;
         if (disturb && lowcnt == 2) in_valid = 1'b0;
         @(negedge clk);
      end
      chk(lowcnt == 19 * m_exp_h, "R7 ready low length", lowcnt, 19 * m_exp_h);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++; n_checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin : stim
      int flen;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      chk(pin_cs_n && pin_sclk && pin_sdo && in_ready, "R1 reset state",
          {pin_cs_n, pin_sclk, pin_sdo, in_ready}, 4'hF);
      rst_n = 1'b1;
      @(negedge clk);
      chk(pin_cs_n && pin_sclk && pin_sdo && in_ready, "R1 idle after reset",
          {pin_cs_n, pin_sclk, pin_sdo, in_ready}, 4'hF);

      // directed corners
      send(8'h00, 16'h00A5, 1, 1'b0, 1'b0);   // R2 command flag clear
      send(8'h80, 16'hFF3C, 0, 1'b0, 1'b0);   // R2 nonzero flag, R5 zero -> one
      send(8'h01, 16'h1200, 3, 1'b0, 1'b1);   // R8 R5 disturbed during frame
      send(8'h00, 16'h00FF, 2, 1'b1, 1'b0);   // back-to-back for R7 gap
      send(8'h01, 16'h0001, 2, 1'b0, 1'b0);
      @(negedge clk);
      chk(pin_cs_n && pin_sclk && pin_sdo && in_ready, "R1 idle after frames",
          {pin_cs_n, pin_sclk, pin_sdo, in_ready}, 4'hF);

      // random traffic
      for (int i = 0; i < 40; i++) begin
         logic [7:0] k;
         k = ($urandom % 3 == 0) ? 8'h00 : 8'($urandom);
         send(k, 16'($urandom), int'($urandom % 6), 1'($urandom), 1'($urandom));
      end
      in_valid = 1'b0;
      repeat (12) @(negedge clk);
      chk(pin_cs_n && pin_sclk && pin_sdo && in_ready, "R1 idle at end",
          {pin_cs_n, pin_sclk, pin_sdo, in_ready}, 4'hF);

      // fixed-divider variant: H = 2, port value ignored (R5)
      f_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      f_valid = 1'b0;
      flen = 0;
      while (!f_ready) begin flen++; @(negedge clk); end
      chk(flen == 38, "R5 fixed half period", flen, 38);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule